// File: doc/BRIEF.md
# System-Management State Save and Resume Sequencer

When a system-management interrupt is accepted, this block takes a snapshot of a processor's architectural register file and writes it into a fixed memory window. On a resume command it reads the snapshot back and hands it to the register file. It drives an active-low "in SMM" indication for the whole time the processor is in that mode. It also refuses accesses to the protected window that arrive while the mode is not active.

The memory side is a valid/ready write/read port. Back-pressure works as follows. Once `mem_valid_o` rises, the address, direction and write data stay unchanged until a cycle in which `mem_ready_i` is high. That cycle completes the transfer, and only then does the sequencer step to the next word. On a read, `mem_rdata_i` is taken in the completing cycle.

Register words travel on `regs_i` as 22 words of 32 bits, in save order: word 0 in bits [31:0] is CR0, then CR3, EFLAGS, EIP, EDI, ESI, EBP, ESP, EBX, EDX, ECX, EAX, DR6, DR7, TR, LDTR, GS, FS, DS, SS, CS, and word 21 is ES. The caller holds `regs_i`, `hlt_slot_i` and `io_slot_i` steady from acceptance until the save ends. The window spans byte addresses 38000h–3FFFFh and cannot be moved.

Top module: `smm_state_sequencer`

## Requirements
- R1: A synchronous active-high reset, even one in the middle of a sequence, leaves `smiact_n_o`=1, `mem_valid_o`=0, `ld_strobe_o`=0 and `bad_rsm_o`=0 on the next cycle. The save and restore slot contents are also cleared.
- R2: An SMI request seen while idle is accepted at the next clock edge. From that cycle `smiact_n_o` is 0 and the first write targets 3FFFCh with register word 0.
- R3: Save writes register word k at byte address 3FFFCh − 4·k, for k = 0..21, with data `regs_i[32k+31:32k]`. The last of these (ES) lands at 3FFA8h.
- R4: After the 22 register words, exactly two further writes follow. The first goes to 3FF00h with data {halt slot[15:0] in bits 31:16, I/O-trap slot[15:0] in bits 15:0}, using the slot inputs captured at acceptance. The second goes to 3FEFCh with data 00010000h. Nothing is written to 3FFA7h–3FF04h, to 3FEFBh–3FE00h, or anywhere else.
- R5: A transfer completes only in a cycle with `mem_valid_o` and `mem_ready_i` both high. While it is stalled, address, direction and data stay stable, so the sequence is identical under any ready pattern.
- R6: A resume strobe received after the save has finished causes 22 reads. They run in reverse order, from 3FFA8h up to 3FFFCh. The cycle after each read completes, `ld_strobe_o` pulses with `ld_idx_o` = the word index k (21 down to 0) and `ld_data_o` = the word read.
- R7: `smiact_n_o` stays 0 through the cycle of the final load pulse (index 0) and returns to 1 on the next cycle.
- R8: A resume strobe while idle causes a one-cycle pulse on `bad_rsm_o` in the next cycle. It causes no memory transfer, and `smiact_n_o` stays 1.
- R9: An SMI request while already in system-management mode is ignored: no further writes, and `smiact_n_o` stays 0.
- R10: `acc_deny_o` is high exactly when `acc_req_i` is high, `acc_addr_i` lies in 38000h–3FFFFh and the mode is not active. `acc_ok_o` is `acc_req_i` and not `acc_deny_o`.
- R11: A resume strobe that arrives during the save sequence is ignored: no illegal-resume pulse, and the save still completes its 24 writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smi_req_i | input | 1 | System-management interrupt request |
| rsm_i | input | 1 | Resume strobe |
| regs_i | input | 704 | Register file snapshot, 22 words in save order |
| hlt_slot_i | input | 16 | Halt-restart slot value |
| io_slot_i | input | 16 | I/O-trap-restart slot value |
| mem_valid_o | output | 1 | Memory transfer request |
| mem_ready_i | input | 1 | Memory ready; completes transfer when valid |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 20 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, taken when a read completes |
| smiact_n_o | output | 1 | Active-low in-SMM indication |
| ld_strobe_o | output | 1 | Restore load pulse |
| ld_idx_o | output | 5 | Restored register index (save order) |
| ld_data_o | output | 32 | Restored register value |
| bad_rsm_o | output | 1 | Illegal-resume pulse |
| acc_req_i | input | 1 | Other-master memory access request |
| acc_addr_i | input | 20 | Address of that access |
| acc_deny_o | output | 1 | Access refused (window hit outside SMM) |
| acc_ok_o | output | 1 | Access allowed |

## Verification
The stall-stability property assumes that the snapshot bus and both slot inputs stay constant from the accepting edge to the last save write. The stimulus changes them only while the sequencer is idle or parked in the mode. The read data is assumed valid in any cycle where ready is high, and the bench memory model always presents the word at the current address. Ready is driven both continuously high and in a one-in-three pattern. Reset, SMI and resume are driven as single-cycle pulses at the falling edge, and they never overlap each other except where a test aims at exactly that case.

// File: rtl/smm_pkg.sv
package smm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAVE,
    ST_ACTV,
    ST_REST,
    ST_LEAVE
  } smm_state_e;

  typedef enum logic [1:0] {
    KIND_REG,
    KIND_RESTART,
    KIND_REVID
  } save_kind_e;
endpackage

// File: rtl/smm_addr_map.sv
module smm_addr_map #(
  parameter int AW    = 20,
  parameter int NREG  = 22,
  parameter int IDX_W = 5,
  parameter logic [AW-1:0] TOP_WORD     = 20'h3FFFC,
  parameter logic [AW-1:0] RESTART_ADDR = 20'h3FF00,
  parameter logic [AW-1:0] REVID_ADDR   = 20'h3FEFC
) (
  input  logic [IDX_W-1:0]      idx_i,
  output logic [AW-1:0]         addr_o,
  output smm_pkg::save_kind_e   kind_o
);
  always_comb begin
    if (idx_i < IDX_W'(NREG)) begin
      kind_o = smm_pkg::KIND_REG;
      addr_o = TOP_WORD - (AW'(idx_i) << 2);
    end else if (idx_i == IDX_W'(NREG)) begin
      kind_o = smm_pkg::KIND_RESTART;
      addr_o = RESTART_ADDR;
    end else begin
      kind_o = smm_pkg::KIND_REVID;
      addr_o = REVID_ADDR;
    end
  end
endmodule

// File: rtl/smm_win_gate.sv
module smm_win_gate #(
  parameter int AW = 20,
  parameter logic [AW-1:0] WIN_LO = 20'h38000,
  parameter logic [AW-1:0] WIN_HI = 20'h3FFFF
) (
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          in_smm_i,
  output logic          deny_o,
  output logic          ok_o
);
  logic hit;
  assign hit    = (addr_i >= WIN_LO) && (addr_i <= WIN_HI);
  assign deny_o = req_i && hit && !in_smm_i;
  assign ok_o   = req_i && !deny_o;
endmodule

// File: rtl/smm_fsm.sv
module smm_fsm #(
  parameter int DW     = 32,
  parameter int NREG   = 22,
  parameter int IDX_W  = 5,
  parameter int REG_IW = 5,
  parameter int SLOT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smi_i,
  input  logic                 rsm_i,
  input  logic                 mem_ready_i,
  input  logic [DW-1:0]        rdata_i,
  input  logic [SLOT_W-1:0]    hlt_i,
  input  logic [SLOT_W-1:0]    io_i,
  output smm_pkg::smm_state_e  state_o,
  output logic [IDX_W-1:0]     cnt_o,
  output logic                 mem_valid_o,
  output logic                 mem_we_o,
  output logic                 load_o,
  output logic [REG_IW-1:0]    load_idx_o,
  output logic [DW-1:0]        load_data_o,
  output logic                 bad_o,
  output logic [SLOT_W-1:0]    hlt_q_o,
  output logic [SLOT_W-1:0]    io_q_o
);
  import smm_pkg::*;

  localparam logic [IDX_W-1:0] LAST_SAVE  = IDX_W'(NREG + 1);
  localparam logic [IDX_W-1:0] FIRST_REST = IDX_W'(NREG - 1);

  smm_state_e state;
  logic [IDX_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      load_o      <= 1'b0;
      load_idx_o  <= '0;
      load_data_o <= '0;
      bad_o       <= 1'b0;
      hlt_q_o     <= '0;
      io_q_o      <= '0;
    end else begin
      load_o <= 1'b0;
      bad_o  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (rsm_i) bad_o <= 1'b1;
          if (smi_i) begin
            state   <= ST_SAVE;
            cnt     <= '0;
            hlt_q_o <= hlt_i;
            io_q_o  <= io_i;
          end
        end
        ST_SAVE: begin
          if (mem_ready_i) begin
            if (cnt == LAST_SAVE) state <= ST_ACTV;
            else                  cnt   <= cnt + 1'b1;
          end
        end
        ST_ACTV: begin
          if (rsm_i) begin
            state <= ST_REST;
            cnt   <= FIRST_REST;
          end
        end
        ST_REST: begin
          if (mem_ready_i) begin
            load_o      <= 1'b1;
            load_idx_o  <= REG_IW'(cnt);
            load_data_o <= rdata_i;
            if (cnt == '0) state <= ST_LEAVE;
            else           cnt   <= cnt - 1'b1;
          end
        end
        ST_LEAVE: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign state_o     = state;
  assign cnt_o       = cnt;
  assign mem_valid_o = (state == ST_SAVE) || (state == ST_REST);
  assign mem_we_o    = (state == ST_SAVE);
endmodule

// File: rtl/smm_state_sequencer.sv
module smm_state_sequencer #(
  parameter int DW     = 32,
  parameter int AW     = 20,
  parameter int NREG   = 22,
  parameter int SLOT_W = 16,
  parameter logic [AW-1:0] WIN_LO       = 20'h38000,
  parameter logic [AW-1:0] WIN_HI       = 20'h3FFFF,
  parameter logic [AW-1:0] RESTART_ADDR = 20'h3FF00,
  parameter logic [AW-1:0] REVID_ADDR   = 20'h3FEFC,
  parameter logic [DW-1:0] REVID_VALUE  = 32'h0001_0000,
  localparam int IDX_W  = $clog2(NREG + 2),
  localparam int REG_IW = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               smi_req_i,
  input  logic               rsm_i,
  input  logic [NREG*DW-1:0] regs_i,
  input  logic [SLOT_W-1:0]  hlt_slot_i,
  input  logic [SLOT_W-1:0]  io_slot_i,
  output logic               mem_valid_o,
  input  logic               mem_ready_i,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [DW-1:0]      mem_wdata_o,
  input  logic [DW-1:0]      mem_rdata_i,
  output logic               smiact_n_o,
  output logic               ld_strobe_o,
  output logic [REG_IW-1:0]  ld_idx_o,
  output logic [DW-1:0]      ld_data_o,
  output logic               bad_rsm_o,
  input  logic               acc_req_i,
  input  logic [AW-1:0]      acc_addr_i,
  output logic               acc_deny_o,
  output logic               acc_ok_o
);
  import smm_pkg::*;

  localparam logic [AW-1:0] TOP_WORD = WIN_HI - AW'(DW / 8 - 1);

  smm_state_e          state;
  save_kind_e          kind;
  logic [IDX_W-1:0]    cnt;
  logic [SLOT_W-1:0]   hlt_q, io_q;
  logic [DW-1:0]       reg_word [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign reg_word[g] = regs_i[g*DW +: DW];
  end

  smm_fsm #(
    .DW(DW), .NREG(NREG), .IDX_W(IDX_W), .REG_IW(REG_IW), .SLOT_W(SLOT_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .smi_i(smi_req_i), .rsm_i(rsm_i),
    .mem_ready_i(mem_ready_i), .rdata_i(mem_rdata_i),
    .hlt_i(hlt_slot_i), .io_i(io_slot_i),
    .state_o(state), .cnt_o(cnt),
    .mem_valid_o(mem_valid_o), .mem_we_o(mem_we_o),
    .load_o(ld_strobe_o), .load_idx_o(ld_idx_o), .load_data_o(ld_data_o),
    .bad_o(bad_rsm_o), .hlt_q_o(hlt_q), .io_q_o(io_q)
  );

  smm_addr_map #(
    .AW(AW), .NREG(NREG), .IDX_W(IDX_W), .TOP_WORD(TOP_WORD),
    .RESTART_ADDR(RESTART_ADDR), .REVID_ADDR(REVID_ADDR)
  ) u_map (
    .idx_i(cnt), .addr_o(mem_addr_o), .kind_o(kind)
  );

  always_comb begin
    unique case (kind)
      KIND_REG:     mem_wdata_o = reg_word[cnt[REG_IW-1:0]];
      KIND_RESTART: mem_wdata_o = DW'({hlt_q, io_q});
      default:      mem_wdata_o = REVID_VALUE;
    endcase
  end

  assign smiact_n_o = (state == ST_IDLE);

  smm_win_gate #(
    .AW(AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_gate (
    .req_i(acc_req_i), .addr_i(acc_addr_i), .in_smm_i(!smiact_n_o),
    .deny_o(acc_deny_o), .ok_o(acc_ok_o)
  );
endmodule

// File: rtl/smm_seq_chk.sv
module smm_seq_chk #(
  parameter int AW   = 20,
  parameter int DW   = 32,
  parameter int NREG = 22,
  parameter logic [AW-1:0] WIN_HI       = 20'h3FFFF,
  parameter logic [AW-1:0] RESTART_ADDR = 20'h3FF00,
  parameter logic [AW-1:0] REVID_ADDR   = 20'h3FEFC
) (
  input logic          clk,
  input logic          rst,
  input logic          smiact_n,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          load,
  input logic          bad,
  input logic          rsm,
  input logic          acc_req,
  input logic          acc_deny
);
  localparam logic [AW-1:0] TOP_W = WIN_HI - AW'(DW / 8 - 1);
  localparam logic [AW-1:0] LOW_W = TOP_W - AW'(4 * (NREG - 1));

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (smiact_n && !mem_valid && !load && !bad));

  assert_xfer_in_smm_R2: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !smiact_n);

  assert_write_map_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_we) |->
      ((mem_addr <= TOP_W && mem_addr >= LOW_W && mem_addr[1:0] == 2'b00) ||
       mem_addr == RESTART_ADDR || mem_addr == REVID_ADDR));

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_load_after_read_R6: assert property (@(posedge clk) disable iff (rst)
    load |-> $past(mem_valid && mem_ready && !mem_we));

  assert_bad_only_idle_R8: assert property (@(posedge clk) disable iff (rst)
    bad |-> $past(rsm && smiact_n));

  assert_deny_outside_R10: assert property (@(posedge clk) disable iff (rst)
    acc_deny |-> (acc_req && smiact_n));
endmodule

bind smm_state_sequencer smm_seq_chk #(
  .AW(AW), .DW(DW), .NREG(NREG), .WIN_HI(WIN_HI),
  .RESTART_ADDR(RESTART_ADDR), .REVID_ADDR(REVID_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .smiact_n(smiact_n_o),
  .mem_valid(mem_valid_o), .mem_ready(mem_ready_i), .mem_we(mem_we_o),
  .mem_addr(mem_addr_o), .mem_wdata(mem_wdata_o),
  .load(ld_strobe_o), .bad(bad_rsm_o), .rsm(rsm_i),
  .acc_req(acc_req_i), .acc_deny(acc_deny_o)
);

// File: tb/tb_smm_state_sequencer.sv
module tb_smm_state_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 22;
  localparam int DW = 32;
  localparam int AW = 20;

  // gate vectors: {req, expected deny while idle, address}
  localparam logic [AW+1:0] GATE_TAB [6] = '{
    {1'b1, 1'b1, 20'h38000}, {1'b1, 1'b1, 20'h3FFFF}, {1'b1, 1'b0, 20'h37FFF},
    {1'b1, 1'b0, 20'h40000}, {1'b0, 1'b0, 20'h3FE00}, {1'b1, 1'b1, 20'h3C124}
  };

  logic clk = 1'b0, rst = 1'b1, smi = 1'b0, rsm = 1'b0;
  logic [NREG*DW-1:0] regs = '0;
  logic [15:0] hlt = '0, io = '0;
  logic mem_valid, mem_ready = 1'b1, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;
  logic smiact_n, ld_strobe, bad_rsm;
  logic [4:0] ld_idx;
  logic [DW-1:0] ld_data;
  logic acc_req = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic acc_deny, acc_ok;

  int tot = 0, bad = 0, cyc = 0;
  int wr_n = 0, rd_n = 0, ld_n = 0, bad_n = 0;
  int stall_mode = 0;
  int lastld_cyc = -10, rise_cyc = -20;
  logic lastld_smiact = 1'b1, prev_smiact = 1'b1;
  logic [AW-1:0] wr_addr [64], rd_addr [64];
  logic [DW-1:0] wr_data [64], ld_dat [64];
  logic [4:0] ld_ix [64];
  logic [DW-1:0] mem [8192];
  bit done = 1'b0;

  smm_state_sequencer dut (
    .clk(clk), .rst(rst), .smi_req_i(smi), .rsm_i(rsm), .regs_i(regs),
    .hlt_slot_i(hlt), .io_slot_i(io),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .smiact_n_o(smiact_n), .ld_strobe_o(ld_strobe), .ld_idx_o(ld_idx),
    .ld_data_o(ld_data), .bad_rsm_o(bad_rsm),
    .acc_req_i(acc_req), .acc_addr_i(acc_addr), .acc_deny_o(acc_deny), .acc_ok_o(acc_ok)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tot++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rv(input logic [31:0] seed, input int k);
    return seed + 32'(k) * 32'h0101_0101;
  endfunction

  // memory model and monitor, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    mem_ready = (stall_mode != 0) ? (cyc % 3 == 0) : 1'b1;
    mem_rdata = mem[mem_addr[14:2]];
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr[14:2]] = mem_wdata;
        if (wr_n < 64) begin wr_addr[wr_n] = mem_addr; wr_data[wr_n] = mem_wdata; end
        wr_n++;
      end else begin
        if (rd_n < 64) rd_addr[rd_n] = mem_addr;
        rd_n++;
      end
    end
    if (ld_strobe) begin
      if (ld_n < 64) begin ld_ix[ld_n] = ld_idx; ld_dat[ld_n] = ld_data; end
      ld_n++;
      if (ld_idx == 5'd0) begin lastld_cyc = cyc; lastld_smiact = smiact_n; end
    end
    if (bad_rsm) bad_n++;
    if (smiact_n && !prev_smiact) rise_cyc = cyc;
    prev_smiact = smiact_n;
  end

  task automatic gate_walk(input bit in_smm);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      acc_req  = GATE_TAB[i][AW+1];
      acc_addr = GATE_TAB[i][AW-1:0];
      #2;
      chk("R10 deny", 32'(acc_deny), in_smm ? 32'd0 : 32'(GATE_TAB[i][AW]));
      chk("R10 ok", 32'(acc_ok), 32'(GATE_TAB[i][AW+1] && !(in_smm ? 1'b0 : GATE_TAB[i][AW])));
    end
    @(negedge clk);
    acc_req = 1'b0;
  endtask

  task automatic do_save(input logic [31:0] seed, input logic [15:0] h, input logic [15:0] i_o,
                         input bit poke_rsm);
    int b0;
    for (int k = 0; k < NREG; k++) regs[k*DW +: DW] = rv(seed, k);
    hlt = h; io = i_o;
    wr_n = 0;
    b0 = bad_n;
    @(negedge clk); smi = 1'b1;
    @(negedge clk); smi = 1'b0;
    chk("R2 smiact low", 32'(smiact_n), 32'd0);
    chk("R2 first addr", 32'(mem_addr), 32'h3FFFC);
    if (poke_rsm) begin
      repeat (5) @(negedge clk);
      rsm = 1'b1;
      @(negedge clk); rsm = 1'b0;
    end
    for (int t = 0; t < 400 && wr_n < 24; t++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R4 write count", 32'(wr_n), 32'd24);
    for (int k = 0; k < NREG; k++) begin
      chk("R3 addr", 32'(wr_addr[k]), 32'h3FFFC - 32'(4 * k));
      chk("R3 data", wr_data[k], rv(seed, k));
    end
    chk("R4 restart addr", 32'(wr_addr[22]), 32'h3FF00);
    chk("R4 restart data", wr_data[22], {h, i_o});
    chk("R4 revid addr", 32'(wr_addr[23]), 32'h3FEFC);
    chk("R4 revid data", wr_data[23], 32'h0001_0000);
    if (poke_rsm) chk("R11 no bad pulse", 32'(bad_n - b0), 32'd0);
    chk("R11 still in smm", 32'(smiact_n), 32'd0);
  endtask

  task automatic do_resume(input logic [31:0] seed);
    rd_n = 0; ld_n = 0;
    @(negedge clk); rsm = 1'b1;
    @(negedge clk); rsm = 1'b0;
    for (int t = 0; t < 400 && !smiact_n; t++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R6 read count", 32'(rd_n), 32'd22);
    chk("R6 load count", 32'(ld_n), 32'd22);
    for (int j = 0; j < NREG; j++) begin
      chk("R6 read addr", 32'(rd_addr[j]), 32'h3FFA8 + 32'(4 * j));
      chk("R6 load idx", 32'(ld_ix[j]), 32'(21 - j));
      chk("R6 load data", ld_dat[j], rv(seed, 21 - j));
    end
    chk("R7 smiact at last load", 32'(lastld_smiact), 32'd0);
    chk("R7 release cycle", 32'(rise_cyc - lastld_cyc), 32'd1);
  endtask

  initial begin
    int w0, r0, b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    chk("R1 smiact", 32'(smiact_n), 32'd1);
    chk("R1 valid", 32'(mem_valid), 32'd0);
    chk("R1 load", 32'(ld_strobe), 32'd0);
    chk("R1 bad", 32'(bad_rsm), 32'd0);

    gate_walk(1'b0);

    // R8: resume while idle
    w0 = wr_n; r0 = rd_n;
    @(negedge clk); rsm = 1'b1;
    @(negedge clk); rsm = 1'b0;
    chk("R8 pulse", 32'(bad_rsm), 32'd1);
    chk("R8 smiact", 32'(smiact_n), 32'd1);
    @(negedge clk);
    chk("R8 one cycle", 32'(bad_rsm), 32'd0);
    chk("R8 no xfer", 32'(wr_n - w0 + rd_n - r0), 32'd0);

    do_save(32'h1234_0000, 16'hBEEF, 16'h00A5, 1'b0);
    gate_walk(1'b1);

    // R9: SMI while in SMM
    wr_n = 0;
    @(negedge clk); smi = 1'b1;
    @(negedge clk); smi = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9 no writes", 32'(wr_n), 32'd0);
    chk("R9 smiact", 32'(smiact_n), 32'd0);

    do_resume(32'h1234_0000);

    // R5 / R11: stalled memory, resume poked mid-save
    stall_mode = 1;
    do_save(32'hC0DE_0007, 16'h0001, 16'h8000, 1'b1);
    do_resume(32'hC0DE_0007);
    stall_mode = 0;

    // R1: reset in the middle of a save
    b0 = bad_n;
    @(negedge clk); smi = 1'b1;
    @(negedge clk); smi = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 mid-save smiact", 32'(smiact_n), 32'd1);
    chk("R1 mid-save valid", 32'(mem_valid), 32'd0);
    @(negedge clk);
    chk("R1 stays idle", 32'(smiact_n), 32'd1);
    chk("R1 bad clear", 32'(bad_n - b0), 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", tot, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tot++; bad++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("test done: total=%0d bad=%0d", tot, bad);
      $finish;
    end
  end
endmodule